// File: doc/BRIEF.md
# Dual-Mode Two-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit-wide first-in first-out buffer whose write side and read side run on their own clocks. The two clocks may be one net or unrelated. The storage depth is a parameter. A strap input, sampled while reset is held, selects one of two read behaviours:

- **Standard mode.** A word leaves storage only when the reader asks for it.
- **Fall-through mode.** The oldest word moves onto the output by itself and is held there until it is taken.

Two fixed flags change meaning with the mode. Three level flags compare the fill level against half the depth and against two offsets. The offsets are loaded through the data input while a load strobe is held: each enabled write cycle fills the next offset slot. The read data passes through an output-enable qualifier.

Top module: `dual_mode_fifo`

## Requirements
- R1: Words leave the FIFO in exactly the order they were accepted, each 18 bits unchanged.
- R2: A write while the storage is full is dropped. The storage holds DEPTH words in standard mode, and DEPTH+1 in fall-through mode, where the extra word sits in the output register.
- R3: In standard mode `ef_or` is high while no word is readable. A word written into an empty FIFO clears `ef_or` two read-clock edges after its write edge, but `rd_data` keeps its old value until an edge on which `rd_en` is high and `ef_or` is low.
- R4: In fall-through mode `ef_or` means output ready. The first word written into an empty FIFO appears on `rd_data`, and `ef_or` rises, three read-clock edges after its write edge, without `rd_en`. The word then stays until an edge with `rd_en` high consumes it.
- R5: `ff_ir` is high when full in standard mode. In fall-through mode it is high when there is room (input ready).
- R6: The mode is taken from `fwft_sel` only while `rst_n` is low. Changing `fwft_sel` after reset has no effect.
- R7: `half_full` is high when the write-side fill level exceeds DEPTH/2.
- R8: `almost_full` is high when the write-side fill level is at least DEPTH minus the almost-full offset.
- R9: `almost_empty` is high when the read-side fill level (stored words, plus the held output word in fall-through mode) is at most the almost-empty offset.
- R10: While `load` is high, each cycle with `wr_en` high stores the low offset-width bits of `wr_data` into an offset register instead of the FIFO. The order is almost-empty offset, then almost-full offset, and the order then repeats. While `load` is low, the next offset slot returns to almost-empty. Both offsets are 7 after reset.
- R11: `rd_drive` follows `oe`, and `rd_data` is all zeros while `oe` is low.
- R12: After reset the FIFO is empty with both offsets at their defaults:
  - in standard mode `ef_or`=1, `ff_ir`=0, `almost_empty`=1, `almost_full`=0, `half_full`=0 and `rd_data`=0;
  - in fall-through mode `ef_or`=0 and `ff_ir`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both sides |
| fwft_sel | input | 1 | Mode strap, 1 selects fall-through, sampled during reset |
| wr_en | input | 1 | Write enable |
| load | input | 1 | Routes enabled writes to the offset registers |
| wr_data | input | 18 | Write data, also offset value during load |
| rd_en | input | 1 | Read enable |
| oe | input | 1 | Output enable qualifier |
| rd_data | output | 18 | Read data, zero while oe is low |
| rd_drive | output | 1 | High when rd_data is driven |
| ef_or | output | 1 | Empty (standard) or output ready (fall-through) |
| ff_ir | output | 1 | Full (standard) or input ready (fall-through) |
| almost_empty | output | 1 | Read-side level at or below the almost-empty offset |
| almost_full | output | 1 | Write-side level within the almost-full offset of DEPTH |
| half_full | output | 1 | Write-side level above DEPTH/2 |

## Verification
A corrupted pointer or a Gray code step that skips shows up as a reordered, lost or repeated word at the next read. The scoreboard catches it in the cycle it happens. A wrong offset slot or a lost sequencer reset moves a threshold flag by one or more words, and this is seen at the next settled level check after the following writes. A wrong synchronizer depth or a wrong output-stage hand-off moves the first-word latency, which the bench pins to the exact read edge in both modes.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  localparam int PTR_MAX = 16;
  typedef logic [PTR_MAX-1:0] ptr_t;

  function automatic ptr_t to_gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(ptr_t g);
    ptr_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // Distance between two wrapping pointers of width pw.
  function automatic ptr_t level_of(ptr_t w, ptr_t r, int unsigned pw);
    ptr_t m;
    m = (ptr_t'(1) << pw) - ptr_t'(1);
    return (w - r) & m;
  endfunction

  function automatic logic af_hit(ptr_t lvl, ptr_t off, int unsigned depth);
    return (int'(lvl) + int'(off)) >= int'(depth);
  endfunction

  function automatic logic hf_hit(ptr_t lvl, int unsigned depth);
    return int'(lvl) > int'(depth / 2);
  endfunction

  function automatic logic ae_hit(ptr_t lvl, ptr_t off);
    return lvl <= off;
  endfunction

endpackage

// File: rtl/dmf_gray_sync.sv
module dmf_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/dmf_store.sv
module dmf_store #(
  parameter int DW    = 18,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/dmf_wr_side.sv
module dmf_wr_side
  import dmf_pkg::*;
#(
  parameter int DW      = 18,
  parameter int DEPTH   = 16,
  parameter int DEF_OFF = 7,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic [PW-1:0] rq2_gray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic [PW-1:0] wgray,
  output logic          ff_ir,
  output logic          almost_full,
  output logic          half_full,
  output logic [PW-1:0] ae_off,
  output logic [PW-1:0] af_off
);

  logic          fwft_q;
  logic [PW-1:0] wbin;
  logic [PW-1:0] wbin_nx;
  logic [PW-1:0] rq2_bin;
  logic [PW-1:0] level_w;
  logic          full;
  logic          push;
  logic          load_take;
  logic          sel_af;

  // Mode strap is only captured while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) fwft_q <= fwft_sel;
  end

  assign rq2_bin   = PW'(from_gray(ptr_t'(rq2_gray)));
  assign level_w   = PW'(level_of(ptr_t'(wbin), ptr_t'(rq2_bin), PW));
  assign full      = (level_w == PW'(DEPTH));
  assign push      = wr_en && !load && !full;
  assign load_take = wr_en && load;
  assign wbin_nx   = wbin + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_nx;
      wgray <= PW'(to_gray(ptr_t'(wbin_nx)));
    end
  end

  // Offset loader: alternates slots while load is held.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_af <= 1'b0;
      ae_off <= PW'(DEF_OFF);
      af_off <= PW'(DEF_OFF);
    end else if (!load) begin
      sel_af <= 1'b0;
    end else if (load_take) begin
      if (sel_af) af_off <= din[PW-1:0];
      else        ae_off <= din[PW-1:0];
      sel_af <= ~sel_af;
    end
  end

  assign waddr       = wbin[AW-1:0];
  assign we          = push;
  assign ff_ir       = fwft_q ? !full : full;
  assign almost_full = af_hit(ptr_t'(level_w), ptr_t'(af_off), DEPTH);
  assign half_full   = hf_hit(ptr_t'(level_w), DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level_w <= PW'(DEPTH)); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> $stable(wbin)); // R2
  AST_LOAD_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> $stable(wbin)); // R10
  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R1

endmodule

// File: rtl/dmf_rd_side.sv
module dmf_rd_side
  import dmf_pkg::*;
#(
  parameter int DW    = 18,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft_sel,
  input  logic          rd_en,
  input  logic [PW-1:0] wq2_gray,
  input  logic [DW-1:0] mem_rdata,
  input  logic [PW-1:0] ae_off,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [DW-1:0] dout,
  output logic          ef_or,
  output logic          almost_empty
);

  logic          fwft_q;
  logic [PW-1:0] rbin;
  logic [PW-1:0] rbin_nx;
  logic [PW-1:0] wq2_bin;
  logic [PW-1:0] mem_level;
  logic [PW-1:0] level_r;
  logic          mem_empty;
  logic          out_valid;
  logic          pop;

  always_ff @(posedge clk) begin
    if (!rst_n) fwft_q <= fwft_sel;
  end

  assign wq2_bin   = PW'(from_gray(ptr_t'(wq2_gray)));
  assign mem_level = PW'(level_of(ptr_t'(wq2_bin), ptr_t'(rbin), PW));
  assign mem_empty = (rgray == wq2_gray);
  assign rbin_nx   = rbin + 1'b1;

  // Fall-through refills the output stage whenever it is free or being taken.
  assign pop = fwft_q ? (!mem_empty && (!out_valid || rd_en))
                      : (rd_en && !mem_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      dout      <= '0;
      out_valid <= 1'b0;
    end else begin
      if (pop) begin
        rbin  <= rbin_nx;
        rgray <= PW'(to_gray(ptr_t'(rbin_nx)));
        dout  <= mem_rdata;
      end
      if (pop)        out_valid <= 1'b1;
      else if (rd_en) out_valid <= 1'b0;
    end
  end

  assign level_r      = mem_level + PW'(fwft_q && out_valid);
  assign raddr        = rbin[AW-1:0];
  assign ef_or        = fwft_q ? out_valid : mem_empty;
  assign almost_empty = ae_hit(ptr_t'(level_r), ptr_t'(ae_off));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_level <= PW'(DEPTH)); // R1
  AST_STD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft_q && !rd_en) |=> $stable(dout)); // R3
  AST_FWFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft_q && out_valid && !rd_en) |=> (out_valid && $stable(dout))); // R4

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DW      = 18,
  parameter int DEPTH   = 16,
  parameter int DEF_OFF = 7,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic          load,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          oe,
  output logic [DW-1:0] rd_data,
  output logic          rd_drive,
  output logic          ef_or,
  output logic          ff_ir,
  output logic          almost_empty,
  output logic          almost_full,
  output logic          half_full
);

  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic          we;
  logic [PW-1:0] wgray;
  logic [PW-1:0] rgray;
  logic [PW-1:0] wq2_gray;
  logic [PW-1:0] rq2_gray;
  logic [PW-1:0] ae_off;
  logic [PW-1:0] af_off;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] dout;

  dmf_wr_side #(.DW(DW), .DEPTH(DEPTH), .DEF_OFF(DEF_OFF)) u_wr (
    .clk(wclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .wr_en(wr_en),
    .load(load), .din(wr_data), .rq2_gray(rq2_gray), .waddr(waddr),
    .we(we), .wgray(wgray), .ff_ir(ff_ir), .almost_full(almost_full),
    .half_full(half_full), .ae_off(ae_off), .af_off(af_off)
  );

  dmf_gray_sync #(.W(PW)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wq2_gray)
  );

  dmf_gray_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rq2_gray)
  );

  dmf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  dmf_rd_side #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .clk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .rd_en(rd_en),
    .wq2_gray(wq2_gray), .mem_rdata(mem_rdata), .ae_off(ae_off),
    .raddr(raddr), .rgray(rgray), .dout(dout), .ef_or(ef_or),
    .almost_empty(almost_empty)
  );

  assign rd_drive = oe;
  assign rd_data  = oe ? dout : '0;

endmodule

// File: tb/dual_mode_fifo_bench.sv
module dual_mode_fifo_bench;
  localparam int DW = 18;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, fwft_sel = 1'b0, wr_en = 1'b0, load = 1'b0;
  logic rd_en = 1'b0, oe = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_drive, ef_or, ff_ir, almost_empty, almost_full, half_full;

  dual_mode_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dual_mode_fifo (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .load(load), .wr_data(wr_data), .rd_en(rd_en), .oe(oe),
    .rd_data(rd_data), .rd_drive(rd_drive), .ef_or(ef_or), .ff_ir(ff_ir),
    .almost_empty(almost_empty), .almost_full(almost_full),
    .half_full(half_full)
  );

  logic [DW-1:0] exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit mode_fwft = 1'b0;
  bit take = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic sb_compare(input string req);
    if (exp_q.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL %s actual=%0h expected=none", req, rd_data);
    end else begin
      chk(req, rd_data, exp_q.pop_front());
    end
  endtask

  // Monitor: decides before the edge, compares the word the read produced.
  always begin
    @(negedge clk); #4;
    take = 1'b0;
    if (rst_n) begin
      if (mode_fwft) begin
        if (rd_en && ef_or && oe) sb_compare("R1/R4 fall-through order");
      end else begin
        take = rd_en && !ef_or;
      end
    end
    @(posedge clk); #1;
    if (take) sb_compare("R1/R3 standard order");
  end

  // Driver tasks: push what the FIFO must accept.
  task automatic put(input logic [DW-1:0] d, input bit accept);
    @(negedge clk); wr_data = d; wr_en = 1'b1;
    if (accept) exp_q.push_back(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic burst(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_data = base + DW'(i); wr_en = 1'b1;
      exp_q.push_back(base + DW'(i));
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load_word(input logic [DW-1:0] d);
    @(negedge clk); load = 1'b1; wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic settle;
    repeat (6) @(negedge clk);
  endtask

  task automatic drain(input string req);
    @(negedge clk); rd_en = 1'b1;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    rd_en = 1'b0;
    chk(req, exp_q.size(), 0);
  endtask

  task automatic do_reset(input bit f);
    @(negedge clk);
    rst_n = 1'b0; fwft_sel = f; mode_fwft = f;
    wr_en = 1'b0; rd_en = 1'b0; load = 1'b0; oe = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    report();
  end

  initial begin
    // ---- standard mode, reset state (R12)
    do_reset(1'b0);
    chk("R12 ef_or", ef_or, 1);
    chk("R12 ff_ir", ff_ir, 0);
    chk("R12 almost_empty", almost_empty, 1);
    chk("R12 almost_full", almost_full, 0);
    chk("R12 half_full", half_full, 0);
    chk("R12 rd_data", rd_data, 0);
    chk("R11 rd_drive on", rd_drive, 1);

    // ---- R6: strap ignored after reset
    fwft_sel = 1'b1;
    settle();
    chk("R6 mode kept standard", ef_or, 1);
    fwft_sel = 1'b0;

    // ---- R3: empty latency, no output without read
    put(18'h2A5A5, 1'b1);
    chk("R3 ef_or after write edge", ef_or, 1);
    @(negedge clk);
    chk("R3 ef_or one edge later", ef_or, 1);
    @(negedge clk);
    chk("R3 ef_or two edges later", ef_or, 0);
    settle();
    chk("R3 no read no data", rd_data, 0);
    drain("R1 single word drained");

    // ---- default thresholds R7 R8 R9, full R2 R5
    burst(7, 18'h100);
    settle();
    chk("R9 ae at 7 words", almost_empty, 1);
    chk("R8 af at 7 words", almost_full, 0);
    put(18'h107, 1'b1); settle();
    chk("R9 ae at 8 words", almost_empty, 0);
    chk("R7 hf at 8 words", half_full, 0);
    chk("R8 af at 8 words", almost_full, 0);
    put(18'h108, 1'b1); settle();
    chk("R7 hf at 9 words", half_full, 1);
    chk("R8 af at 9 words", almost_full, 1);
    burst(7, 18'h109); settle();
    chk("R5 full at DEPTH", ff_ir, 1);
    put(18'h3FFFF, 1'b0); settle();
    chk("R2 still full after dropped write", ff_ir, 1);
    drain("R2 dropped word absent");
    settle();
    chk("R3 empty after drain", ef_or, 1);
    chk("R5 not full after drain", ff_ir, 0);

    // ---- R10 offset loader: ae=5, af=3 (wraps: 2 -> ae, 3 -> af, 5 -> ae)
    load_word(18'd2); load_word(18'd3); load_word(18'd5);
    @(negedge clk); load = 1'b0;
    settle();
    chk("R10 load writes not enqueued", ef_or, 1);
    burst(5, 18'h200); settle();
    chk("R10 ae offset 5 at 5 words", almost_empty, 1);
    put(18'h205, 1'b1); settle();
    chk("R10 ae offset 5 at 6 words", almost_empty, 0);
    burst(6, 18'h206); settle();
    chk("R10 af offset 3 at 12 words", almost_full, 0);
    put(18'h20C, 1'b1); settle();
    chk("R10 af offset 3 at 13 words", almost_full, 1);
    drain("R1 drain after load");

    // ---- R10: slot returns to almost-empty while load is low
    load_word(18'd9);
    @(negedge clk); load = 1'b0;
    @(negedge clk);
    load_word(18'd4);
    @(negedge clk); load = 1'b0;
    burst(4, 18'h300); settle();
    chk("R10 sequencer restart ae at 4", almost_empty, 1);
    put(18'h304, 1'b1); settle();
    chk("R10 sequencer restart ae at 5", almost_empty, 0);
    drain("R1 drain after restart");

    // ---- fall-through mode
    do_reset(1'b1);
    chk("R12 fwft ef_or", ef_or, 0);
    chk("R12 fwft ff_ir", ff_ir, 1);
    put(18'h3C3C3, 1'b1);
    chk("R4 not ready after write edge", ef_or, 0);
    @(negedge clk);
    chk("R4 not ready one edge", ef_or, 0);
    @(negedge clk);
    chk("R4 not ready two edges", ef_or, 0);
    @(negedge clk);
    chk("R4 ready at third edge", ef_or, 1);
    chk("R4 word shown without read", rd_data, 18'h3C3C3);

    // ---- R11 output enable
    oe = 1'b0; #1;
    chk("R11 data gated", rd_data, 0);
    chk("R11 drive off", rd_drive, 0);
    oe = 1'b1; #1;
    chk("R11 data back", rd_data, 18'h3C3C3);
    settle();
    chk("R4 word held", rd_data, 18'h3C3C3);
    drain("R1 fwft single drained");
    settle();
    chk("R4 not ready after drain", ef_or, 0);

    // ---- R2/R5 fall-through capacity DEPTH+1
    burst(16, 18'h400); settle();
    chk("R5 input ready at 16", ff_ir, 1);
    put(18'h410, 1'b1); settle();
    chk("R5 input not ready at 17", ff_ir, 0);
    put(18'h3FFFF, 1'b0); settle();
    drain("R2 fwft capacity order");
    settle();
    chk("R5 input ready after drain", ff_ir, 1);

    report();
  end

endmodule